// File: doc/BRIEF.md
# Keyboard and Display Register Bank

This block is the processor-side register bank for a character input device and a character output device on a 16-bit system bus. A load or store reaches it only in a cycle where the bus enable is high. The store strobe picks the direction, and the 16-bit address picks the register. There are five registers: a status word and a data word for the keyboard, the same pair for the display, and a machine control word whose top bit is the clock-run flag.

Each device has a ready flag in bit 15 of its status word. Hardware sets and clears this flag as a side effect of traffic. A new key character sets keyboard ready, and a processor load of keyboard data clears it. A processor store to display data clears display ready and hands the character to the display. The display's done pulse sets the flag again. Software can write only the interrupt-enable bit, bit 14. Each device raises its interrupt request while both its enable bit and its ready flag are set.

Any enabled access in the page 0xFE00 to 0xFFFF raises a select output, so that external memory stays off the bus. Addresses in that page that match no register read as zero and take no writes.

Top module: `kbd_disp_regs`

## Requirements
- R1: After reset, keyboard ready is 0, display ready is 1, both enables are 0, the run flag is 1, both interrupt requests are 0 and the display strobe is 0.
- R2: When key_valid is high at a clock edge, key_char is stored and keyboard ready becomes 1. Keyboard status at 0xFE00 then reads 0x8000 when its enable bit is 0.
- R3: A load from 0xFE02 returns {8'h00, stored key} in the same cycle and clears keyboard ready at that edge. A load from 0xFE00 changes nothing.
- R4: If a key arrives in the same cycle as a load from 0xFE02, the load returns the previous key and keyboard ready stays 1.
- R5: A store to 0xFE06 captures wdata[7:0] on disp_char, pulses disp_valid high for exactly one cycle and clears display ready. The data word then reads back as {8'h00, char}.
- R6: A disp_done pulse sets display ready. If a store to 0xFE06 occurs in the same cycle, the store wins and ready ends at 0.
- R7: A store to a status word (0xFE00 or 0xFE04) changes only bit 14, the enable. The ready bit is not writable, and bits 13:0 read as 0.
- R8: kbd_irq is high exactly when the keyboard enable and keyboard ready are both 1. disp_irq is high exactly when the display enable and display ready are both 1.
- R9: The control word at 0xFFFE reads {run, 15'b0}. A store sets run to wdata[15], and the run output follows it.
- R10: io_sel is high exactly when bus_en is high and bus_addr[15:9] is all ones. In that page, every address other than the five registers reads 0, and a store to it changes no state.
- R11: While bus_en is low, bus_rdata is 0 and no store or load side effect takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Memory/IO transfer enable for this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 16 | Transfer address |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data (0 when not loading a register) |
| io_sel | output | 1 | Access falls in the I/O page |
| key_valid | input | 1 | New key character present this cycle |
| key_char | input | 8 | Key character code |
| disp_valid | output | 1 | One-cycle strobe: new character for the display |
| disp_char | output | 8 | Character handed to the display |
| disp_done | input | 1 | Display finished its character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |
| run | output | 1 | Clock-run flag from the control word |

## Verification
Every key code from 0 to 255 is sent through the keyboard path, and every character code is stored to the display with nonzero upper data bits. This shows that the full byte is captured and that the upper byte reads as zero. The whole I/O page is swept with loads and compared against a reference model, which separates the five decodes from the unmapped addresses. Stores to the unmapped addresses show that they alias to nothing. Targeted single cycles cover the races: key arrival against a data load, and done against a display store. Further cycles check disabled-bus traffic and writes to the status ready bits, which must have no effect.

// File: rtl/kbd_disp_regs.sv
`timescale 1ns/1ps
module kbd_disp_regs #(
  parameter logic [15:0] KSTAT_A = 16'hFE00,
  parameter logic [15:0] KDATA_A = 16'hFE02,
  parameter logic [15:0] DSTAT_A = 16'hFE04,
  parameter logic [15:0] DDATA_A = 16'hFE06,
  parameter logic [15:0] CTRL_A  = 16'hFFFE,
  parameter int          CW      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        io_sel,
  input  logic        key_valid,
  input  logic [CW-1:0] key_char,
  output logic        disp_valid,
  output logic [CW-1:0] disp_char,
  input  logic        disp_done,
  output logic        kbd_irq,
  output logic        disp_irq,
  output logic        run
);
  localparam int RDY = 15;
  localparam int IEN = 14;

  logic rd, wr, hit_ks, hit_kd, hit_ds, hit_dd, hit_ct;
  logic kbd_rdy, kbd_ie, dsp_rdy, dsp_ie;
  logic [CW-1:0] kbd_char;
  logic unused_wbits;

  assign rd     = bus_en & ~bus_we;
  assign wr     = bus_en & bus_we;
  assign hit_ks = bus_addr == KSTAT_A;
  assign hit_kd = bus_addr == KDATA_A;
  assign hit_ds = bus_addr == DSTAT_A;
  assign hit_dd = bus_addr == DDATA_A;
  assign hit_ct = bus_addr == CTRL_A;
  assign io_sel = bus_en & (&bus_addr[15:9]);
  assign unused_wbits = ^bus_wdata[13:CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_rdy    <= 1'b0;
      kbd_ie     <= 1'b0;
      kbd_char   <= '0;
      dsp_rdy    <= 1'b1;
      dsp_ie     <= 1'b0;
      disp_char  <= '0;
      disp_valid <= 1'b0;
      run        <= 1'b1;
    end else begin
      if (key_valid) begin
        kbd_rdy  <= 1'b1;
        kbd_char <= key_char;
      end else if (rd && hit_kd) begin
        kbd_rdy <= 1'b0;
      end
      if (wr && hit_ks) kbd_ie <= bus_wdata[IEN];
      if (wr && hit_ds) dsp_ie <= bus_wdata[IEN];
      if (wr && hit_ct) run    <= bus_wdata[RDY];
      disp_valid <= wr && hit_dd;
      if (wr && hit_dd) begin
        dsp_rdy   <= 1'b0;
        disp_char <= bus_wdata[CW-1:0];
      end else if (disp_done) begin
        dsp_rdy <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_ks) bus_rdata = {kbd_rdy, kbd_ie, 14'b0};
      if (hit_kd) bus_rdata = {{(16-CW){1'b0}}, kbd_char};
      if (hit_ds) bus_rdata = {dsp_rdy, dsp_ie, 14'b0};
      if (hit_dd) bus_rdata = {{(16-CW){1'b0}}, disp_char};
      if (hit_ct) bus_rdata = {run, 15'b0};
    end
  end

  assign kbd_irq  = kbd_ie & kbd_rdy;
  assign disp_irq = dsp_ie & dsp_rdy;

  // R2
  key_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (bus_rdata[RDY] || !(rd && hit_ks)) && kbd_rdy);
  // R3
  kdata_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_kd && !key_valid) |=> !kbd_rdy && !kbd_irq);
  // R5
  ddata_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_dd) |=> disp_valid && !dsp_rdy && disp_char == $past(bus_wdata[CW-1:0]));
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !(wr && hit_dd)) |=> !disp_valid);
  // R6
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_done && !(wr && hit_dd)) |=> dsp_rdy);
  // R9
  run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_ct) |=> run == $past(bus_wdata[RDY]));
  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(kbd_ie) && $stable(dsp_ie) && $stable(run));
endmodule

// File: tb/kbd_disp_regs_tb.sv
`timescale 1ns/1ps
module kbd_disp_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0, key_valid = 0, disp_done = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] key_char = 0;
  wire [15:0] bus_rdata;
  wire io_sel, disp_valid, kbd_irq, disp_irq, run;
  wire [7:0] disp_char;

  kbd_disp_regs dut_i (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_sel(io_sel),
    .key_valid(key_valid), .key_char(key_char), .disp_valid(disp_valid),
    .disp_char(disp_char), .disp_done(disp_done), .kbd_irq(kbd_irq),
    .disp_irq(disp_irq), .run(run));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic m_krdy, m_kie, m_drdy, m_die, m_run;
  logic [7:0] m_kchar, m_dchar;
  logic [15:0] rd_s;
  logic sel_s;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input logic [15:0] a);
    case (a)
      16'hFE00: return {m_krdy, m_kie, 14'b0};
      16'hFE02: return {8'h00, m_kchar};
      16'hFE04: return {m_drdy, m_die, 14'b0};
      16'hFE06: return {8'h00, m_dchar};
      16'hFFFE: return {m_run, 15'b0};
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic step(input logic en, input logic we, input logic [15:0] a,
                      input logic [15:0] d, input logic kv, input logic [7:0] kc,
                      input logic dn);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    key_valid = kv; key_char = kc; disp_done = dn;
    #1 rd_s = bus_rdata; sel_s = io_sel;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; key_valid = 0; disp_done = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    step(1, 0, a, 16'h0, 0, 8'h0, 0);
  endtask
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    step(1, 1, a, d, 0, 8'h0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_krdy = 0; m_kie = 0; m_drdy = 1; m_die = 0; m_run = 1; m_kchar = 0; m_dchar = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 run", {15'b0, run}, 16'h1);
    check("R1 irqs", {14'b0, kbd_irq, disp_irq}, 16'h0);
    check("R1 strobe", {15'b0, disp_valid}, 16'h0);
    rd(16'hFE00); check("R1 kstat", rd_s, 16'h0000);
    rd(16'hFE04); check("R1 dstat", rd_s, 16'h8000);
    rd(16'hFFFE); check("R1 ctrl", rd_s, 16'h8000);

    // R2/R3 sweep of all key codes
    for (int c = 0; c < 256; c++) begin
      step(0, 0, 16'h0, 16'h0, 1, 8'(c), 0);
      rd(16'hFE00); check("R2 kstat after key", rd_s, 16'h8000);
      rd(16'hFE00); check("R3 kstat read keeps ready", rd_s, 16'h8000);
      rd(16'hFE02); check("R3 kdata value", rd_s, {8'h00, 8'(c)});
      rd(16'hFE00); check("R3 ready cleared", rd_s, 16'h0000);
    end
    m_kchar = 8'hFF;

    // R4 race: key arrives with data load
    step(0, 0, 16'h0, 16'h0, 1, 8'h41, 0);
    step(1, 0, 16'hFE02, 16'h0, 1, 8'h42, 0);
    check("R4 old key returned", rd_s, 16'h0041);
    rd(16'hFE00); check("R4 ready kept", rd_s, 16'h8000);
    rd(16'hFE02); check("R4 new key", rd_s, 16'h0042);
    m_kchar = 8'h42;

    // R7/R8 keyboard
    wr(16'hFE00, 16'hFFFF);
    rd(16'hFE00); check("R7 kstat only ie", rd_s, 16'h4000);
    check("R8 kirq no ready", {15'b0, kbd_irq}, 16'h0);
    step(0, 0, 16'h0, 16'h0, 1, 8'h10, 0);
    check("R8 kirq set", {15'b0, kbd_irq}, 16'h1);
    rd(16'hFE02);
    check("R8 kirq after read", {15'b0, kbd_irq}, 16'h0);
    wr(16'hFE00, 16'hBFFF);
    rd(16'hFE00); check("R7 ie cleared", rd_s, 16'h0000);
    m_kchar = 8'h10;

    // R5/R6 sweep of all display codes
    for (int c = 0; c < 256; c++) begin
      wr(16'hFE06, {8'hA5, 8'(c)});
      check("R5 strobe", {15'b0, disp_valid}, 16'h1);
      check("R5 char", {8'h00, disp_char}, {8'h00, 8'(c)});
      rd(16'hFE04); check("R5 ready cleared", rd_s, 16'h0000);
      check("R5 strobe single", {15'b0, disp_valid}, 16'h0);
      rd(16'hFE06); check("R5 readback", rd_s, {8'h00, 8'(c)});
      step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1);
      rd(16'hFE04); check("R6 done sets ready", rd_s, 16'h8000);
    end
    // R6 race
    step(1, 1, 16'hFE06, 16'h0033, 0, 8'h0, 1);
    rd(16'hFE04); check("R6 store beats done", rd_s, 16'h0000);
    step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1);
    m_dchar = 8'h33;

    // R7/R8 display
    wr(16'hFE04, 16'h7FFF);
    rd(16'hFE04); check("R7 dstat only ie", rd_s, 16'hC000);
    check("R8 dirq set", {15'b0, disp_irq}, 16'h1);
    wr(16'hFE06, 16'h0034);
    check("R8 dirq busy", {15'b0, disp_irq}, 16'h0);
    step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1);
    check("R8 dirq done", {15'b0, disp_irq}, 16'h1);
    m_dchar = 8'h34; m_die = 1;

    // R9 control word
    wr(16'hFFFE, 16'h7FFF);
    check("R9 run off", {15'b0, run}, 16'h0);
    rd(16'hFFFE); check("R9 read off", rd_s, 16'h0000);
    wr(16'hFFFE, 16'h8000);
    check("R9 run on", {15'b0, run}, 16'h1);

    // R10 write unmapped page addresses
    step(0, 0, 16'h0, 16'h0, 1, 8'h77, 0);
    m_krdy = 1; m_kchar = 8'h77;
    for (int a = 16'hFE00; a <= 16'hFFFF; a++) begin
      if (a != 16'hFE00 && a != 16'hFE02 && a != 16'hFE04 && a != 16'hFE06 && a != 16'hFFFE)
        wr(16'(a), 16'h0000);
    end
    // R10 read sweep vs model
    for (int a = 16'hFE00; a <= 16'hFFFF; a++) begin
      logic [15:0] e;
      e = model_rd(16'(a));
      rd(16'(a));
      check("R10 page read", rd_s, e);
      check("R10 io_sel", {15'b0, sel_s}, 16'h1);
      if (a == 16'hFE02) m_krdy = 0;
    end
    rd(16'h3000);
    check("R10 outside sel", {15'b0, sel_s}, 16'h0);
    check("R10 outside data", rd_s, 16'h0);

    // R11 idle bus
    step(0, 1, 16'hFE04, 16'h0000, 0, 8'h0, 0);
    step(0, 1, 16'hFFFE, 16'h0000, 0, 8'h0, 0);
    check("R11 run kept", {15'b0, run}, 16'h1);
    step(0, 0, 16'h0, 16'h0, 1, 8'h55, 0);
    step(0, 0, 16'hFE02, 16'h0, 0, 8'h0, 0);
    check("R11 idle rdata", rd_s, 16'h0000);
    rd(16'hFE04); check("R11 ie kept", rd_s, 16'hC000);
    rd(16'hFE00); check("R11 ready kept", rd_s, 16'h8000);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule